// File: doc/BRIEF.md
# Two-Level Gated Interrupt Controller

This block gathers single-cycle event pulses from three core sources and eight peripheral sources, and keeps a sticky flag and an enable bit for each one in registers that software reads and writes. It raises a single request line to the processor when some flagged and enabled source gets through the gates. Every source must pass a global gate. Peripheral sources must also pass a second, group-level gate.

When the processor signals an instruction boundary while the request is high, the controller takes the interrupt. It pushes the supplied return address onto an internal eight-entry stack, presents a fixed vector address and closes the global gate. A return strobe pops the stack, shows the next saved address and opens the global gate again. Flags are never cleared by hardware. The handler must clear the flag it has served, or the same interrupt is taken again as soon as it returns.

Top module: `intc_top`

## Requirements
- R1: After reset every register reads zero, `irqReq` and `vecTaken` are low, and `resumeAddr` is zero.
- R2: A source flag sets on the clock edge that samples its event, even when its own enable, the group gate and the global gate are all clear.
- R3: A flag stays set until software writes a zero to it. If an event and a software clear of the same flag land on the same edge, the flag stays set. A flag still set after a return requests again at once.
- R4: Register 0 (`regSel`=0) holds the global gate at bit 0 and the peripheral group gate at bit 1. Its core enables sit at bits 2, 3 and 4 (timer, external pin, port change). Its core flags sit at bits 5, 6 and 7 in the same order. A core request is raised only when the global gate is set and some core flag has its enable set.
- R5: Register 1 holds the peripheral enables and register 2 holds the peripheral flags. Bit 7 down to bit 0 of both are: EEPROM write done, A/D done, serial receive ready, comparator 2, comparator 1, oscillator fail, serial transmit ready, timer 1 overflow. A peripheral request also needs the group gate.
- R6: The external pin flag sets on a rising edge of `extPin` only. Holding the pin high does not set the flag again after a clear.
- R7: The port-change flag sets when any bit of `portIn` differs from its value in the previous cycle, in either direction.
- R8: While `irqReq` is high and `instrDone` is high (and `retStb` is low), `vecTaken` is high in the same cycle and `vecAddr` equals the vector parameter (default 0x0004). After that edge the global gate is clear and `irqReq` is low.
- R9: Each entry pushes `retAddr`, and `resumeAddr` shows the most recent saved address. A one-cycle `retStb` pops one entry in last-in, first-out order and sets the global gate.
- R10: Register 3 reads the sticky overflow bit at bit 0 and the count of held entries at bits 4:1. A push onto a full stack is dropped and sets the overflow bit, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrOvf | input | 1 | Timer 0 overflow pulse |
| extPin | input | 1 | External request pin, rising-edge sensitive |
| portIn | input | PORT_W | Port pins watched for change |
| perEvt | input | 8 | Peripheral event pulses, same bit order as R5 |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select 0..3 |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Selected register contents (combinational) |
| instrDone | input | 1 | Instruction boundary from the processor |
| retAddr | input | ADDR_W | Address of the next instruction, pushed on entry |
| retStb | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Interrupt request to the processor |
| vecTaken | output | 1 | Entry accepted this cycle |
| vecAddr | output | ADDR_W | Fixed handler address |
| resumeAddr | output | ADDR_W | Top-of-stack return address |

## Verification
An event pulse or a register write lands on one clock edge, and its effect on `regRdata` and `irqReq` is due at the next falling edge, since both outputs are combinational from registers. `vecTaken` and `vecAddr` are combinational on the inputs, so they are checked in the same cycle that `instrDone` is driven, before the rising edge. The stack top, the global gate and the status register change on that edge, so they are checked one cycle later. The bench drives every input on the falling edge and samples 1 ns after it, which keeps each check inside the cycle where its result is due.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PER_N = 8;
  localparam int CORE_N = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PEN  = 2'd1,
    SEL_PFLG = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic gieClr;
    logic gieSet;
  } ctlStrb_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int AW = 13,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrOvf,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portIn,
  input  logic [PER_N-1:0]  perEvt,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWdata,
  input  ctlStrb_t          strb,
  input  logic [AW-1:0]     retAddr,
  output logic [7:0]        regRdata,
  output logic              gie,
  output logic              grpEn,
  output logic [CORE_N-1:0] coreEn,
  output logic [CORE_N-1:0] coreFlag,
  output logic [PER_N-1:0]  perEn,
  output logic [PER_N-1:0]  perFlag,
  output logic [AW-1:0]     resumeAddr
);
  localparam int PW = $clog2(DEPTH);

  logic              extQ;
  logic [PORT_W-1:0] portQ;
  logic [CORE_N-1:0] coreEvt;
  logic              wrCtrl, wrPen, wrPflg;
  logic [AW-1:0]     stk [DEPTH];
  logic [PW:0]       sp;
  logic              ovf;
  logic              full;
  logic [PW-1:0]     topIdx;

  assign wrCtrl = regWe && (regSel_e'(regSel) == SEL_CTRL);
  assign wrPen  = regWe && (regSel_e'(regSel) == SEL_PEN);
  assign wrPflg = regWe && (regSel_e'(regSel) == SEL_PFLG);

  assign coreEvt = {(portIn != portQ), (extPin && !extQ), tmrOvf};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extQ  <= 1'b0;
      portQ <= '0;
    end else begin
      extQ  <= extPin;
      portQ <= portIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gie      <= 1'b0;
      grpEn    <= 1'b0;
      coreEn   <= '0;
      coreFlag <= '0;
      perEn    <= '0;
    end else begin
      if (strb.gieSet)      gie <= 1'b1;
      else if (strb.gieClr) gie <= 1'b0;
      else if (wrCtrl)      gie <= regWdata[0];
      if (wrCtrl) begin
        grpEn  <= regWdata[1];
        coreEn <= regWdata[4:2];
      end
      coreFlag <= (wrCtrl ? regWdata[7:5] : coreFlag) | coreEvt;
      if (wrPen) perEn <= regWdata;
    end
  end

  for (genvar b = 0; b < PER_N; b++) begin : g_perFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           perFlag[b] <= 1'b0;
      else if (perEvt[b])  perFlag[b] <= 1'b1;
      else if (wrPflg)     perFlag[b] <= regWdata[b];
    end
  end

  assign full   = (sp == (PW+1)'(DEPTH));
  assign topIdx = PW'(sp - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp  <= '0;
      ovf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (strb.pop) begin
      if (sp != '0) sp <= sp - 1'b1;
    end else if (strb.push) begin
      if (full) ovf <= 1'b1;
      else begin
        stk[PW'(sp)] <= retAddr;
        sp           <= sp + 1'b1;
      end
    end
  end

  assign resumeAddr = (sp == '0) ? '0 : stk[topIdx];

  always_comb begin
    unique case (regSel_e'(regSel))
      SEL_CTRL: regRdata = {coreFlag, coreEn, grpEn, gie};
      SEL_PEN:  regRdata = perEn;
      SEL_PFLG: regRdata = perFlag;
      SEL_STAT: regRdata = 8'({sp, ovf});
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic              gie,
  input  logic              grpEn,
  input  logic [CORE_N-1:0] coreEn,
  input  logic [CORE_N-1:0] coreFlag,
  input  logic [PER_N-1:0]  perEn,
  input  logic [PER_N-1:0]  perFlag,
  input  logic              instrDone,
  input  logic              retStb,
  output logic              irqReq,
  output logic              vecTaken,
  output ctlStrb_t          strb
);
  logic coreHit, perHit;

  assign coreHit  = |(coreEn & coreFlag);
  assign perHit   = grpEn && |(perEn & perFlag);
  assign irqReq   = gie && (coreHit || perHit);
  assign vecTaken = irqReq && instrDone && !retStb;

  always_comb begin
    strb        = '0;
    strb.push   = vecTaken;
    strb.gieClr = vecTaken;
    strb.pop    = retStb;
    strb.gieSet = retStb;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int ADDR_W = 13,
  parameter int STACK_D = 8,
  parameter logic [ADDR_W-1:0] VECTOR = 13'h0004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrOvf,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portIn,
  input  logic [7:0]        perEvt,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              instrDone,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic              retStb,
  output logic              irqReq,
  output logic              vecTaken,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [ADDR_W-1:0] resumeAddr
);
  ctlStrb_t          strb;
  logic              gie, grpEn;
  logic [CORE_N-1:0] coreEn, coreFlag;
  logic [PER_N-1:0]  perEn, perFlag;

  intc_datapath #(.PORT_W(PORT_W), .AW(ADDR_W), .DEPTH(STACK_D)) u_dp (
    .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .extPin(extPin), .portIn(portIn),
    .perEvt(perEvt), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .strb(strb), .retAddr(retAddr), .regRdata(regRdata), .gie(gie),
    .grpEn(grpEn), .coreEn(coreEn), .coreFlag(coreFlag), .perEn(perEn),
    .perFlag(perFlag), .resumeAddr(resumeAddr)
  );

  intc_control u_ctl (
    .gie(gie), .grpEn(grpEn), .coreEn(coreEn), .coreFlag(coreFlag),
    .perEn(perEn), .perFlag(perFlag), .instrDone(instrDone), .retStb(retStb),
    .irqReq(irqReq), .vecTaken(vecTaken), .strb(strb)
  );

  assign vecAddr = VECTOR;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int AW = 13,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqReq,
  input logic          vecTaken,
  input logic          retStb,
  input logic [1:0]    regSel,
  input logic          regWe,
  input logic [7:0]    regRdata,
  input logic [AW-1:0] retAddr,
  input logic [AW-1:0] resumeAddr
);
  localparam int DW = $clog2(DEPTH) + 1;
  logic [DW-1:0] depthCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) depthCnt <= '0;
    else if (retStb) begin
      if (depthCnt != '0) depthCnt <= depthCnt - 1'b1;
    end else if (vecTaken && depthCnt < DW'(DEPTH)) depthCnt <= depthCnt + 1'b1;
  end

  // R8: entry closes the global gate, so no request in the following cycle
  a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    vecTaken |=> !irqReq);

  // R9: a stored push shows up at the stack top one cycle later
  a_r9_push_top: assert property (@(posedge clk) disable iff (!rstN)
    (vecTaken && depthCnt < DW'(DEPTH)) |=> (resumeAddr == $past(retAddr)));

  // R9: without push or pop the stack top holds
  a_r9_top_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!vecTaken && !retStb) |=> $stable(resumeAddr));

  // R3: peripheral flags never drop without a write
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd2 && !regWe) |=>
      (regSel != 2'd2 || (regRdata & $past(regRdata)) == $past(regRdata)));

  // R10: overflow bit is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd3 && regRdata[0]) |=> (regSel != 2'd3 || regRdata[0]));
endmodule

bind intc_top intc_checker #(.AW(ADDR_W), .DEPTH(STACK_D)) u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .vecTaken(vecTaken),
  .retStb(retStb), .regSel(regSel), .regWe(regWe), .regRdata(regRdata),
  .retAddr(retAddr), .resumeAddr(resumeAddr)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmrOvf = 1'b0, extPin = 1'b0;
  logic [3:0]  portIn = '0;
  logic [7:0]  perEvt = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        instrDone = 1'b0;
  logic [12:0] retAddr = '0;
  logic        retStb = 1'b0;
  logic        irqReq, vecTaken;
  logic [12:0] vecAddr, resumeAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .extPin(extPin), .portIn(portIn),
    .perEvt(perEvt), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .instrDone(instrDone), .retAddr(retAddr),
    .retStb(retStb), .irqReq(irqReq), .vecTaken(vecTaken), .vecAddr(vecAddr),
    .resumeAddr(resumeAddr)
  );

  // {ctrl, perEn, perFlag, expected irqReq}
  localparam logic [24:0] VEC [10] = '{
    {8'h25, 8'h00, 8'h00, 1'b1},
    {8'h24, 8'h00, 8'h00, 1'b0},
    {8'h41, 8'h00, 8'h00, 1'b0},
    {8'h49, 8'h00, 8'h00, 1'b1},
    {8'h91, 8'h00, 8'h00, 1'b1},
    {8'h03, 8'h10, 8'h10, 1'b1},
    {8'h01, 8'h10, 8'h10, 1'b0},
    {8'h02, 8'hFF, 8'hFF, 1'b0},
    {8'h03, 8'h0F, 8'hF0, 1'b0},
    {8'h03, 8'h01, 8'h01, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] val);
    regWe = 1'b1; regSel = sel; regWdata = val;
    step();
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1;
    val = regRdata;
  endtask

  task automatic enter(input logic [12:0] addr);
    instrDone = 1'b1; retAddr = addr;
    step();
    instrDone = 1'b0;
  endtask

  task automatic leave();
    retStb = 1'b1;
    step();
    retStb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rdReg(2'(s), rv);
      check($sformatf("R1 reg%0d", s), rv, 0);
    end
    check("R1 irqReq", irqReq, 0);
    check("R1 vecTaken", vecTaken, 0);
    check("R1 resumeAddr", resumeAddr, 0);

    // R4 / R5 gating table
    for (int i = 0; i < 10; i++) begin
      wrReg(2'd0, VEC[i][24:17]);
      wrReg(2'd1, VEC[i][16:9]);
      wrReg(2'd2, VEC[i][8:1]);
      #1;
      check($sformatf("R4 R5 vector %0d irqReq", i), irqReq, VEC[i][0]);
      rdReg(2'd0, rv);
      check($sformatf("R4 vector %0d ctrl readback", i), rv, VEC[i][24:17]);
      rdReg(2'd1, rv);
      check($sformatf("R5 vector %0d enable readback", i), rv, VEC[i][16:9]);
    end
    wrReg(2'd0, 8'h00); wrReg(2'd1, 8'h00); wrReg(2'd2, 8'h00);

    // R2 flags latch with everything disabled
    tmrOvf = 1'b1; step(); tmrOvf = 1'b0;
    rdReg(2'd0, rv);
    check("R2 timer flag", rv, 8'h20);
    check("R2 no request", irqReq, 0);
    perEvt = 8'h04; step(); perEvt = 8'h00;
    rdReg(2'd2, rv);
    check("R2 oscillator-fail flag", rv, 8'h04);

    // R3 sticky, software clear, event wins
    repeat (5) step();
    rdReg(2'd0, rv);
    check("R3 flag held", rv, 8'h20);
    wrReg(2'd0, 8'h00);
    rdReg(2'd0, rv);
    check("R3 software clear", rv, 8'h00);
    perEvt = 8'h04;
    wrReg(2'd2, 8'h00);
    perEvt = 8'h00;
    rdReg(2'd2, rv);
    check("R3 event beats clear", rv, 8'h04);
    wrReg(2'd2, 8'h00);
    rdReg(2'd2, rv);
    check("R3 peripheral clear", rv, 8'h00);

    // R6 external pin rising edge
    extPin = 1'b1; step();
    rdReg(2'd0, rv);
    check("R6 rising edge", rv, 8'h40);
    wrReg(2'd0, 8'h00);
    repeat (3) step();
    rdReg(2'd0, rv);
    check("R6 held high no reset", rv, 8'h00);
    extPin = 1'b0; step();
    rdReg(2'd0, rv);
    check("R6 falling edge ignored", rv, 8'h00);
    extPin = 1'b1; step();
    rdReg(2'd0, rv);
    check("R6 second rising edge", rv, 8'h40);
    extPin = 1'b0;
    wrReg(2'd0, 8'h00);

    // R7 port change
    portIn = 4'b0100; step();
    rdReg(2'd0, rv);
    check("R7 change up", rv, 8'h80);
    wrReg(2'd0, 8'h00);
    repeat (3) step();
    rdReg(2'd0, rv);
    check("R7 steady no flag", rv, 8'h00);
    portIn = 4'b0000; step();
    rdReg(2'd0, rv);
    check("R7 change down", rv, 8'h80);
    wrReg(2'd0, 8'h00);

    // R8 entry
    wrReg(2'd0, 8'h25);
    #1;
    check("R8 request before entry", irqReq, 1);
    instrDone = 1'b1; retAddr = 13'h0123;
    #1;
    check("R8 vecTaken", vecTaken, 1);
    check("R8 vecAddr", vecAddr, 13'h0004);
    step();
    instrDone = 1'b0;
    #1;
    check("R8 request gone after entry", irqReq, 0);
    rdReg(2'd0, rv);
    check("R8 gate cleared flag kept", rv, 8'h24);
    check("R9 top after first push", resumeAddr, 13'h0123);
    rdReg(2'd3, rv);
    check("R10 depth one", rv, 8'h02);

    // R9 nesting and return
    wrReg(2'd0, 8'h25);
    enter(13'h0456);
    check("R9 top after nested push", resumeAddr, 13'h0456);
    leave();
    check("R9 top after pop", resumeAddr, 13'h0123);
    rdReg(2'd0, rv);
    check("R9 gate set on return", rv, 8'h25);
    check("R3 refire after return", irqReq, 1);
    wrReg(2'd0, 8'h05);
    #1;
    check("R3 cleared flag quiet", irqReq, 0);
    leave();
    check("R9 empty stack", resumeAddr, 0);
    rdReg(2'd3, rv);
    check("R10 depth zero", rv, 8'h00);

    // R10 overflow
    for (int k = 0; k < 9; k++) begin
      wrReg(2'd0, 8'h25);
      enter(13'(13'h0100 + k));
      if (k == 7) begin
        rdReg(2'd3, rv);
        check("R10 full no overflow", rv, 8'h10);
      end
    end
    rdReg(2'd3, rv);
    check("R10 overflow set", rv, 8'h11);
    check("R10 dropped push", resumeAddr, 13'h0107);
    leave();
    check("R9 pop order", resumeAddr, 13'h0106);
    for (int k = 0; k < 7; k++) leave();
    rdReg(2'd3, rv);
    check("R10 overflow sticky", rv, 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule